// File: doc/BRIEF.md
# Capacity Usage Monitoring Counter Unit

This unit keeps one usage counter for each monitoring ID. Software controls it through a single 64-bit control register. A write names an operation, a monitoring ID, an event selector and an optional access-type filter. The unit either arms or disarms the selected counter, or it copies that counter into a read-only snapshot register.

Each operation completes a fixed two cycles after the write that started it. While the operation runs, a busy flag is set. When it completes, a status code reports the result. Writes that arrive while the unit is busy are dropped.

Counting is driven by a stream of request events. Each event carries a monitoring ID, an access-type and a direction: increment, or decrement when capacity is released. A decrement on a counter that is already at zero marks the counter invalid. This flag is visible in the snapshot.

Top module: `cap_mon_unit`

## Requirements
- R1: The control register reads back with these fields:
  - operation in bits [4:0]
  - access-type in [7:5]
  - monitoring ID in [19:8]
  - event selector in [27:20]
  - access-type-valid in bit 28
  - STATUS in [38:32]
  - BUSY in bit 39

  Bits [31:29] and [63:40] read as zero. The fields other than STATUS and BUSY hold the values of the last accepted write.
- R2: BUSY reads 1 for exactly the two cycles after an accepted write, then reads 0. STATUS reads 0 while BUSY is 1.
- R3: A write while BUSY is 1 is dropped: the operation and the fields already accepted are unchanged.
- R4: Values written into the BUSY and STATUS bit positions have no effect.
- R5: The status codes, checked in this order, are:
  - 2: the operation is neither 1 (configure) nor 2 (snapshot).
  - 3: the monitoring ID is 16 or more.
  - 4: a configure gives an event selector other than 0 or 1.
  - 5: a configure sets access-type-valid with an access-type outside 0..2.
  - 1: otherwise.
- R6: STATUS holds its value until the next accepted write.
- R7: A successful configure with event selector 1 clears the counter and its invalid flag to 0, then counts matching events, one per event.
- R8: With access-type-valid 1, only events whose access-type equals the configured one are counted. With it 0, the access-type field of the write is ignored and every access-type counts.
- R9: A configure with event selector 0 stops the counter, which keeps its value.
- R10: A successful snapshot loads the snapshot register with the count in bits [62:0] and the invalid flag in bit 63. The snapshot register changes on nothing else.
- R11: A decrement event on a counting counter subtracts 1. At zero it leaves the count at 0 and sets the invalid flag.
- R12: After reset the unit reads as follows:
  - BUSY, STATUS and the whole control register read 0.
  - The snapshot register reads 0.
  - Every counter is 0, valid and stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 64 | Control register write data |
| ctl_rdata_o | output | 64 | Control register read value |
| snap_o | output | 64 | Snapshot register: invalid flag in bit 63, count in bits below |
| ev_valid_i | input | 1 | Request event present |
| ev_mcid_i | input | 12 | Monitoring ID of the event |
| ev_at_i | input | 3 | Access-type of the event |
| ev_dec_i | input | 1 | 1 = decrement event, 0 = increment event |

## Verification
The assertions take three things for granted:
- The event inputs and the write strobe are never unknown while out of reset.
- A counter and its configure are only compared on edges where that counter's configure pulse is absent.
- Events on a stopped counter must leave it unchanged.

The stimulus drives every input on the falling clock edge and holds event pulses for one cycle. It keeps events away from the completion cycle of a snapshot, so each snapshot value is fixed by the events issued before that write. It issues writes during BUSY only in the dropped-write test.

// File: rtl/cap_mon_pkg.sv
package cap_mon_pkg;
  localparam int OP_W  = 5;
  localparam int AT_W  = 3;
  localparam int ID_W  = 12;
  localparam int EV_W  = 8;
  localparam int ST_W  = 7;

  localparam logic [OP_W-1:0] OP_CFG  = 5'd1;
  localparam logic [OP_W-1:0] OP_SNAP = 5'd2;

  typedef enum logic [ST_W-1:0] {
    ST_NONE    = 7'd0,
    ST_OK      = 7'd1,
    ST_BAD_OP  = 7'd2,
    ST_BAD_ID  = 7'd3,
    ST_BAD_EVT = 7'd4,
    ST_BAD_AT  = 7'd5
  } status_e;

  typedef struct packed {
    logic [23:0]     rsv_hi;
    logic            busy;
    logic [ST_W-1:0] status;
    logic [2:0]      rsv_lo;
    logic            atv;
    logic [EV_W-1:0] evt;
    logic [ID_W-1:0] mcid;
    logic [AT_W-1:0] at;
    logic [OP_W-1:0] op;
  } ctl_reg_t;

  typedef struct packed {
    logic [OP_W-1:0] op;
    logic [AT_W-1:0] at;
    logic [ID_W-1:0] mcid;
    logic [EV_W-1:0] evt;
    logic            atv;
  } cmd_t;
endpackage

// File: rtl/cap_mon_ctl.sv
module cap_mon_ctl
  import cap_mon_pkg::*;
#(
  parameter int          NUM_MCID = 16,
  parameter logic [7:0]  AT_MASK  = 8'h07,
  parameter int          OP_LAT   = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [63:0] wdata_i,
  output logic        busy_o,
  output status_e     status_o,
  output cmd_t        cmd_o,
  output logic        cfg_fire_o,
  output logic        snap_fire_o
);
  localparam int LW = (OP_LAT > 1) ? $clog2(OP_LAT) : 1;

  ctl_reg_t       wr;
  cmd_t           cmd_q;
  logic           busy_q;
  logic [LW-1:0]  lat_q;
  status_e        status_q;
  status_e        code;
  logic           accept;
  logic           done;
  logic           unused_wbits;

  assign wr           = ctl_reg_t'(wdata_i);
  assign unused_wbits = ^{wr.rsv_hi, wr.busy, wr.status, wr.rsv_lo};
  assign accept       = we_i && !busy_q;
  assign done         = busy_q && (lat_q == '0);

  // result of the pending command, priority op > id > event > access-type
  always_comb begin
    if (cmd_q.op != OP_CFG && cmd_q.op != OP_SNAP)          code = ST_BAD_OP;
    else if (32'(cmd_q.mcid) >= NUM_MCID)                   code = ST_BAD_ID;
    else if (cmd_q.op == OP_CFG && cmd_q.evt > 8'd1)        code = ST_BAD_EVT;
    else if (cmd_q.op == OP_CFG && cmd_q.atv && !AT_MASK[cmd_q.at]) code = ST_BAD_AT;
    else                                                    code = ST_OK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      lat_q    <= '0;
      status_q <= ST_NONE;
      cmd_q    <= '0;
    end else if (accept) begin
      busy_q   <= 1'b1;
      lat_q    <= LW'(OP_LAT - 1);
      status_q <= ST_NONE;
      cmd_q    <= '{op: wr.op, at: wr.at, mcid: wr.mcid, evt: wr.evt, atv: wr.atv};
    end else if (done) begin
      busy_q   <= 1'b0;
      status_q <= code;
    end else if (busy_q) begin
      lat_q    <= lat_q - 1'b1;
    end
  end

  assign busy_o      = busy_q;
  assign status_o    = status_q;
  assign cmd_o       = cmd_q;
  assign cfg_fire_o  = done && (code == ST_OK) && (cmd_q.op == OP_CFG);
  assign snap_fire_o = done && (code == ST_OK) && (cmd_q.op == OP_SNAP);

  // R2
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(we_i));
  // R2
  status_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> status_q == ST_NONE);
  // R3
  drop_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && we_i) |=> $stable(cmd_q));
  // R6
  status_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |=> (busy_q || $stable(status_q)));

  generate
    if (OP_LAT >= 2) begin : g_len
      // R2
      busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_q) |=> busy_q);
    end
  endgenerate
endmodule

// File: rtl/cap_mon_ctr.sv
module cap_mon_ctr
  import cap_mon_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_i,
  input  logic [EV_W-1:0]  cfg_evt_i,
  input  logic             cfg_atv_i,
  input  logic [AT_W-1:0]  cfg_at_i,
  input  logic             hit_i,
  input  logic [AT_W-1:0]  ev_at_i,
  input  logic             ev_dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             inv_o
);
  logic            armed_q;
  logic            atv_q;
  logic [AT_W-1:0] at_q;
  logic            match;

  assign match = hit_i && armed_q && (!atv_q || ev_at_i == at_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      atv_q   <= 1'b0;
      at_q    <= '0;
      cnt_o   <= '0;
      inv_o   <= 1'b0;
    end else if (cfg_i) begin
      armed_q <= (cfg_evt_i != '0);
      if (cfg_evt_i != '0) begin
        atv_q <= cfg_atv_i;
        at_q  <= cfg_at_i;
        cnt_o <= '0;
        inv_o <= 1'b0;
      end
    end else if (match) begin
      if (!ev_dec_i)          cnt_o <= cnt_o + 1'b1;
      else if (cnt_o == '0)   inv_o <= 1'b1;
      else                    cnt_o <= cnt_o - 1'b1;
    end
  end

  // R9
  frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q && !cfg_i) |=> ($stable(cnt_o) && $stable(inv_o)));
  // R11
  inv_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(inv_o) |-> $past(hit_i && ev_dec_i && cnt_o == '0));
  // R7
  arm_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i && cfg_evt_i != '0) |=> (cnt_o == '0 && !inv_o));
endmodule

// File: rtl/cap_mon_bank.sv
module cap_mon_bank
  import cap_mon_pkg::*;
#(
  parameter int NUM_MCID = 16,
  parameter int CNT_W    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_fire_i,
  input  cmd_t             cmd_i,
  input  logic             ev_valid_i,
  input  logic [ID_W-1:0]  ev_mcid_i,
  input  logic [AT_W-1:0]  ev_at_i,
  input  logic             ev_dec_i,
  output logic [CNT_W-1:0] rd_cnt_o,
  output logic             rd_inv_o
);
  localparam int IDX_W = (NUM_MCID > 1) ? $clog2(NUM_MCID) : 1;

  logic [CNT_W-1:0] cnt_a [NUM_MCID];
  logic             inv_a [NUM_MCID];
  logic [IDX_W-1:0] rd_sel;
  logic             unused_op;

  assign unused_op = ^cmd_i.op;
  assign rd_sel    = cmd_i.mcid[IDX_W-1:0];

  generate
    for (genvar i = 0; i < NUM_MCID; i++) begin : g_ctr
      cap_mon_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .cfg_i     (cfg_fire_i && cmd_i.mcid == ID_W'(i)),
        .cfg_evt_i (cmd_i.evt),
        .cfg_atv_i (cmd_i.atv),
        .cfg_at_i  (cmd_i.at),
        .hit_i     (ev_valid_i && ev_mcid_i == ID_W'(i)),
        .ev_at_i   (ev_at_i),
        .ev_dec_i  (ev_dec_i),
        .cnt_o     (cnt_a[i]),
        .inv_o     (inv_a[i])
      );
    end
  endgenerate

  assign rd_cnt_o = cnt_a[rd_sel];
  assign rd_inv_o = inv_a[rd_sel];
endmodule

// File: rtl/cap_mon_unit.sv
module cap_mon_unit
  import cap_mon_pkg::*;
#(
  parameter int         NUM_MCID = 16,
  parameter int         CNT_W    = 32,
  parameter logic [7:0] AT_MASK  = 8'h07,
  parameter int         OP_LAT   = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ctl_we_i,
  input  logic [63:0] ctl_wdata_i,
  output logic [63:0] ctl_rdata_o,
  output logic [63:0] snap_o,
  input  logic        ev_valid_i,
  input  logic [11:0] ev_mcid_i,
  input  logic [2:0]  ev_at_i,
  input  logic        ev_dec_i
);
  logic             busy;
  status_e          status;
  cmd_t             cmd;
  logic             cfg_fire;
  logic             snap_fire;
  logic [CNT_W-1:0] rd_cnt;
  logic             rd_inv;
  logic [63:0]      snap_q;
  ctl_reg_t         rd;

  cap_mon_ctl #(.NUM_MCID(NUM_MCID), .AT_MASK(AT_MASK), .OP_LAT(OP_LAT)) u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (ctl_we_i),
    .wdata_i     (ctl_wdata_i),
    .busy_o      (busy),
    .status_o    (status),
    .cmd_o       (cmd),
    .cfg_fire_o  (cfg_fire),
    .snap_fire_o (snap_fire)
  );

  cap_mon_bank #(.NUM_MCID(NUM_MCID), .CNT_W(CNT_W)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_fire_i (cfg_fire),
    .cmd_i      (cmd),
    .ev_valid_i (ev_valid_i),
    .ev_mcid_i  (ev_mcid_i),
    .ev_at_i    (ev_at_i),
    .ev_dec_i   (ev_dec_i),
    .rd_cnt_o   (rd_cnt),
    .rd_inv_o   (rd_inv)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        snap_q <= '0;
    else if (snap_fire) snap_q <= {rd_inv, {(63 - CNT_W){1'b0}}, rd_cnt};
  end

  always_comb begin
    rd        = '0;
    rd.busy   = busy;
    rd.status = status;
    rd.atv    = cmd.atv;
    rd.evt    = cmd.evt;
    rd.mcid   = cmd.mcid;
    rd.at     = cmd.at;
    rd.op     = cmd.op;
  end

  assign ctl_rdata_o = rd;
  assign snap_o      = snap_q;

  // R10
  snap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_fire |=> $stable(snap_q));
  // R10
  snap_needs_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(snap_q) |-> $fell(busy));
endmodule

// File: tb/cap_mon_unit_bench.sv
module cap_mon_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic [63:0] snap;
  logic        ev_valid = 1'b0;
  logic [11:0] ev_mcid = '0;
  logic [2:0]  ev_at = '0;
  logic        ev_dec = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  cap_mon_unit u_cap_mon_unit (
    .clk_i(clk), .rst_ni(rst_n), .ctl_we_i(we), .ctl_wdata_i(wdata),
    .ctl_rdata_o(rdata), .snap_o(snap), .ev_valid_i(ev_valid),
    .ev_mcid_i(ev_mcid), .ev_at_i(ev_at), .ev_dec_i(ev_dec)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: act=hung exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [4:0] op, input logic [2:0] at,
                                     input logic [11:0] id, input logic [7:0] ev,
                                     input logic atv);
    return {35'd0, atv, ev, id, at, op};
  endfunction

  // drive one write; returns at the falling edge after completion
  task automatic wr(input logic [63:0] d, input bit chk_busy);
    @(negedge clk); we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
    if (chk_busy) begin
      check("R2 busy c1", {63'd0, rdata[39]}, 64'd1);
      check("R2 status c1", {57'd0, rdata[38:32]}, 64'd0);
    end
    @(negedge clk);
    if (chk_busy) check("R2 busy c2", {63'd0, rdata[39]}, 64'd1);
    @(negedge clk);
    if (chk_busy) check("R2 busy done", {63'd0, rdata[39]}, 64'd0);
  endtask

  task automatic ev(input logic [11:0] id, input logic [2:0] at, input logic dec);
    @(negedge clk); ev_valid = 1'b1; ev_mcid = id; ev_at = at; ev_dec = dec;
    @(negedge clk); ev_valid = 1'b0; ev_dec = 1'b0;
  endtask

  task automatic snap_of(input logic [11:0] id);
    wr(mk(5'd2, 3'd0, id, 8'd0, 1'b0), 1'b0);
  endtask

  // {op, at, mcid, evt, atv, expected status}
  localparam logic [31:0] VEC [12] = '{
    {5'd0,  3'd0, 12'd0,    8'd0,   1'b0, 3'd2},
    {5'd3,  3'd1, 12'd1,    8'd1,   1'b0, 3'd2},
    {5'd25, 3'd0, 12'd2,    8'd1,   1'b0, 3'd2},
    {5'd1,  3'd0, 12'd16,   8'd1,   1'b0, 3'd3},
    {5'd2,  3'd0, 12'd4095, 8'd0,   1'b0, 3'd3},
    {5'd1,  3'd0, 12'd2,    8'd2,   1'b0, 3'd4},
    {5'd1,  3'd0, 12'd2,    8'd200, 1'b0, 3'd4},
    {5'd1,  3'd5, 12'd2,    8'd1,   1'b1, 3'd5},
    {5'd1,  3'd5, 12'd2,    8'd1,   1'b0, 3'd1},
    {5'd2,  3'd0, 12'd15,   8'd0,   1'b0, 3'd1},
    {5'd1,  3'd0, 12'd16,   8'd2,   1'b0, 3'd3},
    {5'd0,  3'd0, 12'd16,   8'd9,   1'b0, 3'd2}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 ctl reset", rdata, 64'd0);
    check("R12 snap reset", snap, 64'd0);

    for (int i = 0; i < 12; i++) begin
      logic [63:0] d;
      logic [63:0] exp;
      d   = mk(VEC[i][31:27], VEC[i][26:24], VEC[i][23:12], VEC[i][11:4], VEC[i][3]);
      exp = d | ({61'd0, VEC[i][2:0]} << 32);
      wr(d, i == 0);
      check($sformatf("R5 R1 vec%0d", i), rdata, exp);
    end
    check("R12 counter reset", snap, 64'd0);

    // counting, no filter
    wr(mk(5'd1, 3'd6, 12'd3, 8'd1, 1'b0), 1'b0);
    ev(12'd3, 3'd0, 1'b0); ev(12'd3, 3'd1, 1'b0); ev(12'd3, 3'd7, 1'b0);
    ev(12'd3, 3'd2, 1'b0); ev(12'd3, 3'd3, 1'b0);
    ev(12'd4, 3'd0, 1'b0); ev(12'd4, 3'd0, 1'b0);
    snap_of(12'd3);
    check("R7 R8 count all at", snap, 64'd5);

    // access-type filter
    wr(mk(5'd1, 3'd2, 12'd5, 8'd1, 1'b1), 1'b0);
    for (int k = 0; k < 3; k++) ev(12'd5, 3'd2, 1'b0);
    for (int k = 0; k < 2; k++) ev(12'd5, 3'd1, 1'b0);
    snap_of(12'd5);
    check("R8 at filter", snap, 64'd3);

    // freeze
    wr(mk(5'd1, 3'd0, 12'd3, 8'd0, 1'b0), 1'b0);
    check("R9 freeze status", {57'd0, rdata[38:32]}, 64'd1);
    for (int k = 0; k < 4; k++) ev(12'd3, 3'd0, 1'b0);
    snap_of(12'd3);
    check("R9 frozen value", snap, 64'd5);

    // re-arm clears
    wr(mk(5'd1, 3'd0, 12'd3, 8'd1, 1'b0), 1'b0);
    snap_of(12'd3);
    check("R7 rearm clears", snap, 64'd0);

    // decrement and underflow
    ev(12'd3, 3'd0, 1'b0); ev(12'd3, 3'd0, 1'b0); ev(12'd3, 3'd0, 1'b1);
    snap_of(12'd3);
    check("R11 dec", snap, 64'd1);
    ev(12'd3, 3'd0, 1'b1); ev(12'd3, 3'd0, 1'b1);
    snap_of(12'd3);
    check("R11 underflow inv", snap, 64'h8000_0000_0000_0000);
    wr(mk(5'd1, 3'd0, 12'd3, 8'd1, 1'b0), 1'b0);
    snap_of(12'd3);
    check("R7 inv cleared", snap, 64'd0);

    // snapshot register only changes on snapshot
    snap_of(12'd5);
    check("R10 snap 5", snap, 64'd3);
    wr(mk(5'd1, 3'd0, 12'd5, 8'd1, 1'b0), 1'b0);
    check("R10 hold over cfg", snap, 64'd3);
    snap_of(12'd20);
    check("R10 bad id status", {57'd0, rdata[38:32]}, 64'd3);
    check("R10 hold over bad snap", snap, 64'd3);
    snap_of(12'd5);
    check("R10 snap after clear", snap, 64'd0);

    // written busy/status bits ignored
    wr(mk(5'd2, 3'd0, 12'd5, 8'd0, 1'b0) | 64'h0000_00FF_0000_0000, 1'b1);
    check("R4 ignored bits", rdata, mk(5'd2, 3'd0, 12'd5, 8'd0, 1'b0) | 64'h0000_0001_0000_0000);

    // write while busy dropped
    @(negedge clk); we = 1'b1; wdata = mk(5'd1, 3'd0, 12'd6, 8'd1, 1'b0);
    @(negedge clk); wdata = mk(5'd0, 3'd0, 12'd9, 8'd0, 1'b0);
    @(negedge clk); we = 1'b0;
    @(negedge clk);
    check("R3 dropped write", rdata, mk(5'd1, 3'd0, 12'd6, 8'd1, 1'b0) | 64'h0000_0001_0000_0000);

    // status holds
    for (int k = 0; k < 5; k++) ev(12'd6, 3'd0, 1'b0);
    check("R6 status held", {57'd0, rdata[38:32]}, 64'd1);
    snap_of(12'd6);
    check("R7 dropped write no effect on count", snap, 64'd5);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule